// File: doc/BRIEF.md
# Vector Status and Control Register

This block keeps the 32-bit status and control word of a SIMD unit. Only two bits of that word carry meaning. One is a mode bit: it tells the floating-point datapath whether to handle denormal values in full IEEE fashion (0) or to flush them to zero for speed (1). The other is a sticky saturation flag. Any saturating vector operation in any lane sets this flag, and it stays set until software clears it.

Software writes the word from the least significant 32 bits of a 128-bit vector register and reads it back into a whole vector register. On read-back the upper 96 bits are zero. Every bit other than the two defined ones always reads as zero. The execution lanes report saturation through a per-lane pulse vector, one bit per lane, each clock.

Bit positions follow big-endian numbering inside the 32-bit word. Word bit 0 is the most significant bit. The mode bit is word bit 15, which is vector bit 16. The saturation flag is word bit 31, which is vector bit 0.

Top module: `vec_status_ctrl`

## Requirements
- R1: After reset, `rd_data` is all zero and `flush_mode` is 0.
- R2: A write (`wr_en`=1) loads the mode bit from `wr_data[16]` at the next clock edge. The new value shows on `flush_mode` and on `rd_data[16]`.
- R3: A write with no saturation pulse in the same cycle loads the flag from `wr_data[0]`. A 0 in that bit clears the flag and a 1 sets it. The flag shows on `rd_data[0]`.
- R4: Once set, the saturation flag stays 1 through any number of cycles without a write.
- R5: If any bit of `sat_lanes` is 1, the flag is 1 after that clock edge, whatever lane the pulse came from.
- R6: When a write and a saturation pulse fall in the same cycle, the flag ends at 1, even if `wr_data[0]` is 0.
- R7: Every bit of `rd_data` other than bits 16 and 0 reads 0, whatever value was last written to it. This includes the upper 96 bits.
- R8: Saturation pulses never change the mode bit.
- R9: Without a write, the mode bit holds its value.
- R10: Driving `rst_n` low clears both bits at once, without waiting for a clock edge. The block leaves reset two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the move-to operation |
| wr_data | input | 128 | Source vector; the low 32 bits carry the new word |
| sat_lanes | input | 16 | Per-lane saturation pulses from the execution lanes |
| rd_data | output | 128 | Read-back vector: the status word in the low 32 bits, upper bits zero |
| flush_mode | output | 1 | Mode bit for the floating-point datapath (1 = flush denormals) |

## Verification
A wrong mode bit shows on `flush_mode` and on `rd_data[16]` one clock after the write or pulse that corrupted it. A flag that is lost or set by mistake shows on `rd_data[0]` at the same edge. A reserved bit that leaks shows as a nonzero bit of `rd_data` in that cycle. For these reasons the bench keeps a behavioural model of the two bits and compares the full 128-bit read-back and the mode output after every edge. Any error in the next state is caught within one cycle.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

  // Map a big-endian bit number within a word to a little-endian index.
  function automatic int unsigned be_to_le(input int unsigned be_pos,
                                           input int unsigned word_w);
    return word_w - 1 - be_pos;
  endfunction

  typedef struct packed {
    logic mode;
    logic sat;
  } vsc_state_t;

endpackage

// File: rtl/vsc_rst_sync.sv
module vsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

  initial begin
    stages_min_chk: assert (STAGES >= 2);
  end
endmodule

// File: rtl/vsc_mode_reg.sv
module vsc_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic mode_q
);
  logic mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mode_q == $past(wr_bit));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/vsc_sat_sticky.sv
module vsc_sat_sticky #(
  parameter int unsigned LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [LANES-1:0] sat_lanes,
  output logic             sat_q
);
  logic any_sat;
  logic base;
  logic sat_d;

  always_comb begin
    any_sat = |sat_lanes;
    base    = wr_en ? wr_bit : sat_q;
    sat_d   = base | any_sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_q <= 1'b0;
    else        sat_q <= sat_d;
  end

  // R4
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !wr_en) |=> sat_q);

  // R5
  sat_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_lanes != '0) |=> sat_q);

  // R3
  sat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit && sat_lanes == '0) |=> !sat_q);
endmodule

// File: rtl/vsc_readout.sv
module vsc_readout #(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned MODE_IDX = 16,
  parameter int unsigned SAT_IDX  = 0
) (
  input  vsc_pkg::vsc_state_t state,
  output logic [VEC_W-1:0]    rd_data
);
  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    if (i == MODE_IDX) begin : g_mode
      assign rd_data[i] = state.mode;
    end else if (i == SAT_IDX) begin : g_sat
      assign rd_data[i] = state.sat;
    end else begin : g_rsvd
      assign rd_data[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vec_status_ctrl.sv
module vec_status_ctrl #(
  parameter int unsigned VEC_W       = 128,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned LANES       = 16,
  parameter int unsigned MODE_BE     = 15,
  parameter int unsigned SAT_BE      = 31,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [LANES-1:0] sat_lanes,
  output logic [VEC_W-1:0] rd_data,
  output logic             flush_mode
);
  localparam int unsigned MODE_IDX = vsc_pkg::be_to_le(MODE_BE, WORD_W);
  localparam int unsigned SAT_IDX  = vsc_pkg::be_to_le(SAT_BE, WORD_W);
  localparam logic [VEC_W-1:0] DEF_MASK =
    (VEC_W'(1) << MODE_IDX) | (VEC_W'(1) << SAT_IDX);

  logic                rst_sync_n;
  vsc_pkg::vsc_state_t state;

  vsc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vsc_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_bit (wr_data[MODE_IDX]),
    .mode_q (state.mode)
  );

  vsc_sat_sticky #(.LANES(LANES)) u_sat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_bit    (wr_data[SAT_IDX]),
    .sat_lanes (sat_lanes),
    .sat_q     (state.sat)
  );

  vsc_readout #(.VEC_W(VEC_W), .MODE_IDX(MODE_IDX), .SAT_IDX(SAT_IDX)) u_rd (
    .state   (state),
    .rd_data (rd_data)
  );

  assign flush_mode = state.mode;

  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (wr_data & ~DEF_MASK) != '0) |=> (rd_data & ~DEF_MASK) == '0);

  // R6
  wr_sat_race_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && sat_lanes != '0) |=> rd_data[SAT_IDX]);

  // R8
  mode_no_sat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && sat_lanes != '0) |=> flush_mode == $past(flush_mode));
endmodule

// File: tb/vec_status_ctrl_test.sv
module vec_status_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [127:0] wr_data;
  logic [15:0]  sat_lanes;
  logic [127:0] rd_data;
  logic         flush_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit ref_mode = 1'b0;
  bit ref_sat  = 1'b0;

  always #4 clk = ~clk;

  vec_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sat_lanes(sat_lanes), .rd_data(rd_data), .flush_mode(flush_mode)
  );

  function automatic logic [127:0] expect_rd();
    logic [127:0] v = '0;
    v[16] = ref_mode;
    v[0]  = ref_sat;
    return v;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (rd_data !== expect_rd()) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, expect_rd());
    end
    n_cmp++;
    if (flush_mode !== ref_mode) begin
      n_bad++;
      $display("FAIL %s flush_mode actual=%0b expected=%0b", tag, flush_mode, ref_mode);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, update model, compare.
  task automatic step(input bit w, input logic [127:0] d, input logic [15:0] l,
                      input string tag);
    wr_en = w; wr_data = d; sat_lanes = l;
    @(posedge clk);
    if (w) begin
      ref_mode = d[16];
      ref_sat  = d[0];
    end
    if (l != 0) ref_sat = 1'b1;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; sat_lanes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");

    // R2: mode set and cleared through vector bit 16
    step(1'b1, 128'h0001_0000, '0, "R2");
    step(1'b0, '0, '0, "R9");
    step(1'b0, '0, '0, "R9");
    step(1'b1, 128'h0, '0, "R2");

    // R3: write sets, then clears the flag
    step(1'b1, 128'h1, '0, "R3");
    step(1'b1, 128'h0, '0, "R3");

    // R5: each lane alone sets the flag; R4 keeps it
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 128'h0, '0, "R3");
      step(1'b0, '0, 16'(1) << i, "R5");
      step(1'b0, '0, '0, "R4");
    end
    repeat (5) step(1'b0, '0, '0, "R4");

    // R6: write of 0 racing a pulse
    step(1'b1, 128'h0001_0000, 16'h8000, "R6");
    step(1'b1, 128'h0, 16'h0001, "R6");

    // R8: pulses never move the mode bit
    step(1'b1, 128'h0001_0000, '0, "R2");
    step(1'b0, '0, 16'hFFFF, "R8");
    step(1'b0, '0, 16'h0F0F, "R8");

    // R7: reserved and upper bits written as ones read zero
    step(1'b1, ~128'h0001_0001, '0, "R7");
    step(1'b1, {128{1'b1}}, '0, "R7");
    step(1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE_FFFE, '0, "R7");

    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      step(($urandom() % 4) == 0, rnd128(),
           (($urandom() % 3) == 0) ? 16'($urandom()) : 16'h0, "R7");
    end

    // R10: asynchronous clear mid-cycle
    step(1'b1, 128'h0001_0001, '0, "R2");
    #1 rst_n = 1'b0;
    #1;
    ref_mode = 1'b0; ref_sat = 1'b0;
    compare("R10");
    wr_en = 1'b0; wr_data = '0; sat_lanes = '0;
    @(negedge clk);
    rst_n = 1'b1;
    // a write in the first edge after release must be ignored
    wr_en = 1'b1; wr_data = 128'h0001_0001;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    compare("R10");
    @(negedge clk);
    step(1'b1, 128'h0001_0000, '0, "R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule